// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block sits between a set of shared external interrupt lines and the local interrupt inputs of a small cluster of cores. Each shared line owns a destination core set, a mode word, a mask bit and an edge-pending flag. A line in fixed mode raises its interrupt at every core in its destination set. A line in round-robin mode hands each new assertion to a single core, stepping through the destination set so that the load is spread across those cores.

Software drives the block through a one-cycle command port. An opcode selects the operation, a line index picks the shared line, and a data word carries the operand. Commands write or read a line's destination set, mode word and mask, acknowledge a line's edge-pending state, and switch the whole unit on. Read results appear on a registered read port. Core `c` sees line `l` on output bit `c*NUM_LINES + l`.

Top module: `idu_top`

## Requirements
- R1: After reset every line is masked, every destination set and mode word reads back as zero, and all interrupt outputs are low.
- R2: Until an enable command (opcode 8) has been accepted, no output is asserted, whatever the line state.
- R3: A mask command (opcode 5) stores data bit 0 in the addressed line's mask. A 1 blocks all delivery of that line and a 0 allows it. Reading the mask (opcode 6) returns the stored bit.
- R4: A destination command (opcode 1) stores data bits [NUM_CORES-1:0] as the line's destination set, with bit c standing for core c. Reading the set (opcode 2) returns it.
- R5: The mode word (written with opcode 3, read with opcode 4) keeps the distribution type in bits [1:0] and the trigger type in bit 4. Other bits are dropped on write and read back as zero.
- R6: A distribution type of 0, 2 or 3 selects fixed delivery. While the line is active, every core in the destination set sees the line asserted on output bit `c*NUM_LINES + l`.
- R7: With trigger bit 0 (active-high level), an unmasked line's outputs follow its input one clock later.
- R8: With trigger bit 1 (rising edge), a rising input edge latches pending, and the outputs rise two clocks after the edge. They stay high after the input falls, until an acknowledge command (opcode 7) clears pending. The outputs drop one clock after the acknowledge.
- R9: An acknowledge on a level-mode line has no effect on its outputs.
- R10: Distribution type 1 selects round-robin delivery. Each new assertion goes to exactly one core: the next core of the destination set after the last core served, wrapping past the highest core. The first pick after reset starts the search at core 0.
- R11: A line with an empty destination set delivers nothing. In round-robin mode such an assertion leaves the last-served core unchanged.
- R12: A read command places its result on `rd_data` at the next clock edge, and the value holds until the next read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 4 | Opcode (1 set dest, 2 read dest, 3 set mode, 4 read mode, 5 set mask, 6 read mask, 7 ack, 8 enable) |
| cmd_line | input | LINE_W | Shared line index |
| cmd_data | input | DATA_W | Write operand |
| irq_in | input | NUM_LINES | Shared interrupt lines, active high |
| rd_data | output | DATA_W | Registered read result |
| core_irq_o | output | NUM_CORES*NUM_LINES | Per-core local interrupt inputs, bit c*NUM_LINES+l |

## Verification
The assertions assume that `irq_in` is synchronous to `clk` and that reset is held across at least one clock edge before any command is issued. The round-robin single-core property also assumes that a line's mode is not switched while that line is active. The bench changes inputs only at falling edges. It changes a line's mode or destination set only while that line's input is low and its pending flag is clear. Out-of-range line indices are never issued.

// File: rtl/idu_pkg.sv
package idu_pkg;

    localparam int OP_W     = 4;
    localparam int MODE_W   = 5;
    localparam int DIST_LSB = 0;
    localparam int TRIG_BIT = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_SET_DEST  = 4'd1,
        OP_READ_DEST = 4'd2,
        OP_SET_MODE  = 4'd3,
        OP_READ_MODE = 4'd4,
        OP_SET_MASK  = 4'd5,
        OP_READ_MASK = 4'd6,
        OP_ACK       = 4'd7,
        OP_ENABLE    = 4'd8
    } idu_op_e;

    localparam logic [1:0] DIST_FIXED = 2'd0;
    localparam logic [1:0] DIST_RR    = 2'd1;

    typedef struct packed {
        logic       trig_edge;
        logic [1:0] distr;
    } mode_t;

    function automatic logic [MODE_W-1:0] mode_to_word(input mode_t m);
        logic [MODE_W-1:0] w;
        w = '0;
        w[DIST_LSB +: 2] = m.distr;
        w[TRIG_BIT]      = m.trig_edge;
        return w;
    endfunction

    function automatic mode_t word_to_mode(input logic [MODE_W-1:0] w);
        mode_t m;
        m.distr     = w[DIST_LSB +: 2];
        m.trig_edge = w[TRIG_BIT];
        return m;
    endfunction

    function automatic logic is_read_op(input idu_op_e op);
        return (op == OP_READ_DEST) || (op == OP_READ_MODE) || (op == OP_READ_MASK);
    endfunction

endpackage

// File: rtl/idu_rr_sel.sv
module idu_rr_sel #(
    parameter  int NUM_CORES = 4,
    localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [NUM_CORES-1:0] dest,
    input  logic [IDX_W-1:0]     last,
    output logic                 found,
    output logic [IDX_W-1:0]     pick
);

    // Scan from the farthest candidate to the nearest one, so the
    // nearest set bit after the last served core is the one kept.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = NUM_CORES; k >= 1; k--) begin
            idx = (int'(last) + k) % NUM_CORES;
            if (dest[idx]) begin
                found = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/idu_line.sv
module idu_line
    import idu_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 irq_in,
    input  logic                 wr_dest,
    input  logic                 wr_mode,
    input  logic                 wr_mask,
    input  logic                 ack,
    input  logic [NUM_CORES-1:0] dest_wdata,
    input  mode_t                mode_wdata,
    input  logic                 mask_wdata,
    output logic [NUM_CORES-1:0] dest_o,
    output mode_t                mode_o,
    output logic                 mask_o,
    output logic [NUM_CORES-1:0] grant_o
);

    logic [NUM_CORES-1:0] dest_q;
    mode_t                mode_q;
    logic                 mask_q;
    logic                 pend_q;
    logic                 in_q;
    logic                 act_q;
    logic [NUM_CORES-1:0] grant_q;
    logic [NUM_CORES-1:0] grant_nxt;
    logic [IDX_W-1:0]     last_q;

    logic                 rise;
    logic                 act;
    logic                 act_rise;
    logic                 is_rr;
    logic                 found;
    logic [IDX_W-1:0]     pick;
    logic [NUM_CORES-1:0] pick_oh;
    logic [NUM_CORES-1:0] last_oh;

    assign rise     = irq_in & ~in_q;
    assign is_rr    = (mode_q.distr == DIST_RR);
    assign act      = en & ~mask_q & (mode_q.trig_edge ? pend_q : irq_in);
    assign act_rise = act & ~act_q;
    assign pick_oh  = NUM_CORES'(1) << pick;
    assign last_oh  = NUM_CORES'(1) << last_q;

    idu_rr_sel #(.NUM_CORES(NUM_CORES)) u_rr_sel (
        .dest  (dest_q),
        .last  (last_q),
        .found (found),
        .pick  (pick)
    );

    always_comb begin
        if (!act)
            grant_nxt = '0;
        else if (!is_rr)
            grant_nxt = dest_q;
        else if (act_rise)
            grant_nxt = found ? pick_oh : '0;
        else
            grant_nxt = grant_q & last_oh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q  <= '0;
            mode_q  <= '0;
            mask_q  <= 1'b1;
            pend_q  <= 1'b0;
            in_q    <= 1'b0;
            act_q   <= 1'b0;
            grant_q <= '0;
            last_q  <= IDX_W'(NUM_CORES - 1);
        end else begin
            in_q    <= irq_in;
            act_q   <= act;
            grant_q <= grant_nxt;
            pend_q  <= mode_q.trig_edge & (rise | (pend_q & ~ack));
            if (wr_dest) dest_q <= dest_wdata;
            if (wr_mode) mode_q <= mode_wdata;
            if (wr_mask) mask_q <= mask_wdata;
            if (is_rr && act_rise && found) last_q <= pick;
        end
    end

    assign dest_o  = dest_q;
    assign mode_o  = mode_q;
    assign mask_o  = mask_q;
    assign grant_o = grant_q;

endmodule

// File: rtl/idu_top.sv
module idu_top
    import idu_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    parameter  int NUM_CORES = 4,
    parameter  int DATA_W    = 32,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int OUT_W     = NUM_CORES * NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [OUT_W-1:0]  core_irq_o
);

    idu_op_e              op;
    logic                 line_ok;
    logic                 en_q;
    logic [DATA_W-1:0]    rd_q;
    logic [DATA_W-1:0]    rd_next;
    logic                 unused_cmd_bits;

    logic [NUM_CORES-1:0] dest_arr [NUM_LINES];
    mode_t                mode_arr [NUM_LINES];
    logic [NUM_LINES-1:0] mask_vec;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] rr_vec;

    mode_t                mode_wdata;

    assign op              = idu_op_e'(cmd_op);
    assign line_ok         = (int'(cmd_line) < NUM_LINES);
    assign mode_wdata      = word_to_mode(cmd_data[MODE_W-1:0]);
    assign unused_cmd_bits = ^cmd_data;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (cmd_valid && op == OP_ENABLE)
            en_q <= 1'b1;
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic                 hit;
        logic [NUM_CORES-1:0] grant;
        mode_t                mode_l;

        assign hit = cmd_valid && (cmd_line == LINE_W'(l));

        idu_line #(.NUM_CORES(NUM_CORES)) u_line (
            .clk        (clk),
            .rst        (rst),
            .en         (en_q),
            .irq_in     (irq_in[l]),
            .wr_dest    (hit && op == OP_SET_DEST),
            .wr_mode    (hit && op == OP_SET_MODE),
            .wr_mask    (hit && op == OP_SET_MASK),
            .ack        (hit && op == OP_ACK),
            .dest_wdata (cmd_data[NUM_CORES-1:0]),
            .mode_wdata (mode_wdata),
            .mask_wdata (cmd_data[0]),
            .dest_o     (dest_arr[l]),
            .mode_o     (mode_l),
            .mask_o     (mask_vec[l]),
            .grant_o    (grant)
        );

        assign mode_arr[l] = mode_l;
        assign edge_vec[l] = mode_l.trig_edge;
        assign rr_vec[l]   = (mode_l.distr == DIST_RR);

        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign core_irq_o[c*NUM_LINES + l] = grant[c];
        end
    end

    always_comb begin
        rd_next = rd_q;
        if (cmd_valid && is_read_op(op)) begin
            rd_next = '0;
            if (line_ok) begin
                case (op)
                    OP_READ_DEST: rd_next = DATA_W'(dest_arr[cmd_line]);
                    OP_READ_MODE: rd_next = DATA_W'(mode_to_word(mode_arr[cmd_line]));
                    OP_READ_MASK: rd_next = DATA_W'(mask_vec[cmd_line]);
                    default:      rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= rd_next;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/idu_checker.sv
module idu_checker
    import idu_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    parameter  int NUM_CORES = 4,
    parameter  int DATA_W    = 32,
    localparam int OUT_W     = NUM_CORES * NUM_LINES
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en_q,
    input logic                 cmd_valid,
    input logic [OP_W-1:0]      cmd_op,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] mask_vec,
    input logic [NUM_LINES-1:0] edge_vec,
    input logic [NUM_LINES-1:0] rr_vec,
    input logic [DATA_W-1:0]    rd_data,
    input logic [OUT_W-1:0]     core_irq_o
);

    localparam logic [DATA_W-1:0] RSVD_MASK = ~DATA_W'(5'b10011);

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !$past(en_q) |-> core_irq_o == '0); // R2

    AST_MODE_RSVD: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == OP_READ_MODE) |-> (rd_data & RSVD_MASK) == '0); // R5

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
        logic [NUM_CORES-1:0] col;
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
            assign col[c] = core_irq_o[c*NUM_LINES + l];
        end

        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            $past(mask_vec[l]) |-> col == '0); // R3

        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            $past(!edge_vec[l] && !irq_in[l]) |-> col == '0); // R7

        AST_RR_SINGLE: assert property (@(posedge clk) disable iff (rst)
            (rr_vec[l] && $past(rr_vec[l])) |-> $onehot0(col)); // R10
    end

endmodule

bind idu_top idu_checker #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_q       (en_q),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .irq_in     (irq_in),
    .mask_vec   (mask_vec),
    .edge_vec   (edge_vec),
    .rr_vec     (rr_vec),
    .rd_data    (rd_data),
    .core_irq_o (core_irq_o)
);

// File: tb/idu_top_tb.sv
`timescale 1ns/1ps
module idu_top_tb;
    import idu_pkg::*;

    localparam int NL = 4;
    localparam int NC = 4;
    localparam int DW = 32;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [LW-1:0] cmd_line = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [NL-1:0] irq_in = '0;
    logic [DW-1:0] rd_data;
    logic [NC*NL-1:0] core_irq_o;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    idu_top #(.NUM_LINES(NL), .NUM_CORES(NC), .DATA_W(DW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_line   (cmd_line),
        .cmd_data   (cmd_data),
        .irq_in     (irq_in),
        .rd_data    (rd_data),
        .core_irq_o (core_irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(input idu_op_e op, input int line, input logic [DW-1:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_line  = LW'(line);
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_data  = '0;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] col_bits(input int l, input logic [NC-1:0] d);
        logic [DW-1:0] v;
        v = '0;
        for (int c = 0; c < NC; c++) v[c*NL + l] = d[c];
        return v;
    endfunction

    function automatic int next_core(input int last, input logic [NC-1:0] d);
        for (int k = 1; k <= NC; k++) begin
            if (d[(last + k) % NC]) return (last + k) % NC;
        end
        return -1;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int last2;
        int last3;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        chk("R1 outputs", DW'(core_irq_o), '0);
        for (int l = 0; l < NL; l++) begin
            do_cmd(OP_READ_MASK, l, '0); chk("R1 mask", rd_data, 1);
            do_cmd(OP_READ_DEST, l, '0); chk("R1 dest", rd_data, 0);
            do_cmd(OP_READ_MODE, l, '0); chk("R1 mode", rd_data, 0);
        end

        // R2: nothing before enable
        do_cmd(OP_SET_DEST, 0, 32'hF);
        do_cmd(OP_SET_MASK, 0, 32'h0);
        irq_in[0] = 1'b1;
        tick(3);
        chk("R2 pre-enable", DW'(core_irq_o), '0);
        do_cmd(OP_ENABLE, 0, '0);
        tick(1);
        chk("R2 post-enable", DW'(core_irq_o), col_bits(0, 4'hF));
        irq_in[0] = 1'b0;
        tick(1);

        // R6 R7: fixed level sweep over every line and destination set
        for (int l = 0; l < NL; l++) do_cmd(OP_SET_MASK, l, 32'h0);
        for (int l = 0; l < NL; l++) begin
            for (int d = 0; d < 16; d++) begin
                do_cmd(OP_SET_DEST, l, DW'(d));
                irq_in[l] = 1'b1;
                tick(1);
                chk("R6 fixed deliver", DW'(core_irq_o), col_bits(l, NC'(d)));
                irq_in[l] = 1'b0;
                tick(1);
                chk("R7 level release", DW'(core_irq_o), '0);
            end
        end

        // R3: mask blocks delivery, unmask allows it
        for (int l = 0; l < NL; l++) begin
            do_cmd(OP_SET_DEST, l, 32'hF);
            do_cmd(OP_SET_MASK, l, 32'h1);
            do_cmd(OP_READ_MASK, l, '0);
            chk("R3 mask readback 1", rd_data, 1);
            irq_in[l] = 1'b1;
            tick(2);
            chk("R3 masked silent", DW'(core_irq_o), '0);
            do_cmd(OP_SET_MASK, l, 32'hFFFF_FFFE);
            tick(1);
            chk("R3 unmasked deliver", DW'(core_irq_o), col_bits(l, 4'hF));
            do_cmd(OP_READ_MASK, l, '0);
            chk("R3 mask readback 0", rd_data, 0);
            irq_in[l] = 1'b0;
            tick(1);
        end

        // R4: destination readback
        for (int l = 0; l < NL; l++) begin
            for (int d = 0; d < 16; d += 3) begin
                do_cmd(OP_SET_DEST, l, DW'(d) | 32'hFFFF_FF00);
                do_cmd(OP_READ_DEST, l, '0);
                chk("R4 dest readback", rd_data, DW'(d));
            end
        end

        // R5: mode layout and reserved bits
        do_cmd(OP_SET_MODE, 1, 32'hFFFF_FFFF);
        do_cmd(OP_READ_MODE, 1, '0);
        chk("R5 mode all ones", rd_data, 32'h13);
        do_cmd(OP_SET_MODE, 1, 32'h0000_000E);
        do_cmd(OP_READ_MODE, 1, '0);
        chk("R5 mode type 2", rd_data, 32'h2);
        do_cmd(OP_SET_DEST, 1, 32'h5);
        irq_in[1] = 1'b1;
        tick(1);
        chk("R6 type 2 is fixed", DW'(core_irq_o), col_bits(1, 4'h5));
        irq_in[1] = 1'b0;
        tick(1);

        // R8: edge trigger, hold until acknowledge
        do_cmd(OP_SET_MODE, 1, 32'h10);
        do_cmd(OP_SET_DEST, 1, 32'h3);
        irq_in[1] = 1'b1;
        tick(1);
        chk("R8 edge latency", DW'(core_irq_o), '0);
        irq_in[1] = 1'b0;
        tick(1);
        chk("R8 edge deliver", DW'(core_irq_o), col_bits(1, 4'h3));
        tick(3);
        chk("R8 edge held", DW'(core_irq_o), col_bits(1, 4'h3));
        do_cmd(OP_ACK, 1, '0);
        tick(1);
        chk("R8 ack clears", DW'(core_irq_o), '0);

        // R9: ack in level mode does nothing
        do_cmd(OP_SET_DEST, 0, 32'hF);
        irq_in[0] = 1'b1;
        tick(1);
        do_cmd(OP_ACK, 0, '0);
        tick(1);
        chk("R9 level ack ignored", DW'(core_irq_o), col_bits(0, 4'hF));
        irq_in[0] = 1'b0;
        tick(1);

        // R10 R11: round robin, level trigger, line 2
        last2 = NC - 1;
        do_cmd(OP_SET_MODE, 2, 32'h1);
        foreach (rr_pat[i]) begin
            do_cmd(OP_SET_DEST, 2, DW'(rr_pat[i]));
            for (int p = 0; p < 5; p++) begin
                int nc;
                nc = next_core(last2, rr_pat[i]);
                irq_in[2] = 1'b1;
                tick(1);
                if (nc < 0)
                    chk("R11 empty set silent", DW'(core_irq_o), '0);
                else begin
                    chk("R10 rr next core", DW'(core_irq_o), col_bits(2, NC'(1) << nc));
                    last2 = nc;
                end
                irq_in[2] = 1'b0;
                tick(1);
            end
        end

        // R10: round robin with edge trigger, line 3
        last3 = NC - 1;
        do_cmd(OP_SET_MODE, 3, 32'h11);
        do_cmd(OP_SET_DEST, 3, 32'hB);
        for (int p = 0; p < 6; p++) begin
            int nc;
            nc = next_core(last3, 4'hB);
            irq_in[3] = 1'b1;
            tick(1);
            irq_in[3] = 1'b0;
            tick(1);
            chk("R10 rr edge", DW'(core_irq_o), col_bits(3, NC'(1) << nc));
            last3 = nc;
            do_cmd(OP_ACK, 3, '0);
            tick(1);
            chk("R8 rr ack clears", DW'(core_irq_o), '0);
        end

        // R12: read result holds across non-read commands
        do_cmd(OP_READ_DEST, 3, '0);
        chk("R12 read", rd_data, 32'hB);
        do_cmd(OP_SET_DEST, 1, 32'h6);
        tick(2);
        chk("R12 hold", rd_data, 32'hB);

        done = 1'b1;
        finish_run();
    end

    logic [NC-1:0] rr_pat [7] = '{4'hF, 4'h5, 4'hA, 4'h9, 4'h0, 4'h8, 4'h7};

endmodule